// File: doc/BRIEF.md
# Skip-Mask Instruction Sequencer

This block sits in the fetch path of a processor core. It decides which instruction slots after a branch target actually run. A jump-with-skip operation hands it a 32-bit operand. The low part of the operand is the target address. The high part is a skip pattern, with one bit per slot starting at the target. A set bit means that slot must not execute.

The sequencer produces the address to fetch next. It also raises a cancel flag for the slot at that address and a stall request while it evaluates long runs of skips.

How skipped slots are handled depends on where code is executing. When code runs from local memory, the sequencer steps the address straight past skipped slots, so they cost no cycles. That step is taken in windows of eight bits, and a full window of skips costs a short reload stall. When code is streamed from a FIFO, it cannot jump ahead. Each skipped slot is still fetched, shows up with the cancel flag set, and takes one cycle as a NOP. For every update, the block reports how many slots it passed over, so that a repeat-loop counter outside the block can correct its count of issued instructions.

Top module: `skip_seq`

## Requirements
- R1: On a load, operand bits [9:0] become the fetch address, zero-extended to the address width, and operand bits [31:10] become the skip pattern. Pattern bit 0 governs the slot at the target, bit 1 the next slot, and so on.
- R2: In local mode, `fetch_addr_o` only ever presents slots whose pattern bit is clear. Each advance reaches the next executed slot with no extra cycles for the skipped ones, and `cancel_o` stays low.
- R3: In local mode, a run of r consecutive set bits stalls for 2*floor(r/8) cycles (`stall_o` high): each complete group of eight skips costs two cycles. Runs of seven or fewer never stall. Streamed mode never stalls.
- R4: In streamed mode, every advance moves `fetch_addr_o` up by exactly one. `cancel_o` is high exactly while the presented slot's pattern bit is set.
- R5: `valid_o` is high while unconsumed set bits remain in the pattern, and low once they are all used up.
- R6: A taken branch or return (`branch_i`) clears the pattern and `valid_o`, ends any stall, and puts `branch_addr_i` on `fetch_addr_o` in the next cycle. After that, advances step by one.
- R7: A load while a pattern is active replaces it completely. No bit of the earlier pattern affects later slots.
- R8: `dropped_o` gives the number of slots passed over by the previous cycle's update in local mode (0 to 8). Over a whole pattern, these values sum to the number of set bits. In streamed mode it is 0.
- R9: While `stall_o` is high, `adv_i` is ignored and `fetch_addr_o` holds.
- R10: The execution mode is captured at load (and at branch). Changing `stream_mode_i` afterwards does not alter how the active pattern is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Jump-with-skip: load target and pattern from `operand_i` |
| operand_i | input | 32 | {pattern[21:0], target[9:0]} |
| branch_i | input | 1 | Taken branch or implied return; cancels the pattern |
| branch_addr_i | input | PC_W | Destination of `branch_i` |
| adv_i | input | 1 | Current slot consumed; advance fetch |
| stream_mode_i | input | 1 | 1 = streamed execution, 0 = local memory |
| fetch_addr_o | output | PC_W | Address of the current slot |
| cancel_o | output | 1 | Current slot is a cancelled NOP |
| stall_o | output | 1 | Fetch must wait (skip-window reload) |
| valid_o | output | 1 | Skip pattern active |
| dropped_o | output | $clog2(WIN+1) | Slots passed over by the last update |

## Verification
The bench targets runs of exactly seven, eight, fifteen and twenty-two skips in local mode. An off-by-one in the window-full test would either stall on seven skips or land on a skipped slot after eight. It issues a branch in the middle of a reload stall; a design that did not abort the reload would keep stalling and then jump away from the branch address. It reloads a pattern in the middle of a streamed run and then flips the mode input. Leftover bits, or a live mode input, would then cancel the wrong slots. Random patterns are checked in both modes against an address list and a stall count derived in the bench from the run lengths. The sum of `dropped_o` is also checked, so a miscounted hop would show up as a wrong repeat-loop correction.

// File: rtl/skp_seq_pkg.sv
package skp_seq_pkg;
  localparam int TGT_W = 10;
  localparam int PAT_W = 22;
  localparam int OP_W  = TGT_W + PAT_W;

  typedef struct packed {
    logic [PAT_W-1:0] pat;
    logic [TGT_W-1:0] tgt;
  } skp_op_t;
endpackage

// File: rtl/skp_window_scan.sv
// Counts the leading run of set bits (from bit 0) inside one evaluation window.
module skp_window_scan #(
  parameter int WIN = 8
) (
  input  logic [WIN-1:0]             win_i,
  output logic [$clog2(WIN+1)-1:0]   run_o,
  output logic                       full_o
);
  localparam int CW = $clog2(WIN+1);

  always_comb begin
    logic chain;
    chain = 1'b1;
    run_o = '0;
    for (int i = 0; i < WIN; i++) begin
      chain = chain & win_i[i];
      run_o = run_o + CW'(chain);
    end
    full_o = chain;
  end
endmodule

// File: rtl/skp_reload_timer.sv
// Counts the stall cycles spent fetching the next window after a full one.
module skp_reload_timer #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYC+1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_W'(CYC);
    else if (abort_i)        cnt_q <= '0;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  AST_RELOAD_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && !start_i && !abort_i) |=> busy_o); // R3
endmodule

// File: rtl/skip_seq.sv
module skip_seq
  import skp_seq_pkg::*;
#(
  parameter int PC_W       = 20,
  parameter int WIN        = 8,
  parameter int RELOAD_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [OP_W-1:0]          operand_i,
  input  logic                     branch_i,
  input  logic [PC_W-1:0]          branch_addr_i,
  input  logic                     adv_i,
  input  logic                     stream_mode_i,
  output logic [PC_W-1:0]          fetch_addr_o,
  output logic                     cancel_o,
  output logic                     stall_o,
  output logic                     valid_o,
  output logic [$clog2(WIN+1)-1:0] dropped_o
);
  localparam int DW = $clog2(WIN+1);

  skp_op_t op;
  assign op = skp_op_t'(operand_i);

  logic [PC_W-1:0]  pc_q, pc_d, base_pc;
  logic [PAT_W-1:0] pat_q, pat_d, base_pat;
  logic             stream_q, stream_d;
  logic [DW-1:0]    drop_q, drop_d;
  logic             resolve, reload_start, redirect;
  logic [DW-1:0]    run;
  logic             full;
  logic             busy, done;
  logic             slot_skipped;

  // Pick the base state for this cycle's update.
  always_comb begin
    base_pc  = pc_q;
    base_pat = pat_q;
    stream_d = stream_q;
    resolve  = 1'b0;
    if (load_i) begin
      base_pc  = PC_W'(op.tgt);
      base_pat = op.pat;
      stream_d = stream_mode_i;
      resolve  = !stream_mode_i;
    end else if (branch_i) begin
      base_pc  = branch_addr_i;
      base_pat = '0;
      stream_d = stream_mode_i;
    end else if (busy) begin
      resolve  = done;
    end else if (adv_i) begin
      base_pc  = pc_q + PC_W'(1);
      base_pat = pat_q >> 1;
      resolve  = !stream_q;
    end
  end

  skp_window_scan #(.WIN(WIN)) scan_i (
    .win_i  (base_pat[WIN-1:0]),
    .run_o  (run),
    .full_o (full)
  );

  // Local mode: hop over the leading skips inside the window.
  always_comb begin
    pc_d         = base_pc;
    pat_d        = base_pat;
    drop_d       = '0;
    reload_start = 1'b0;
    if (resolve) begin
      if (full) begin
        pc_d         = base_pc + PC_W'(WIN);
        pat_d        = base_pat >> WIN;
        drop_d       = DW'(WIN);
        reload_start = 1'b1;
      end else begin
        pc_d   = base_pc + PC_W'(run);
        pat_d  = base_pat >> run;
        drop_d = run;
      end
    end
  end

  assign redirect = load_i | branch_i;

  skp_reload_timer #(.CYC(RELOAD_CYC)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (reload_start),
    .abort_i (redirect),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      pat_q    <= '0;
      stream_q <= 1'b0;
      drop_q   <= '0;
    end else begin
      pc_q     <= pc_d;
      pat_q    <= pat_d;
      stream_q <= stream_d;
      drop_q   <= drop_d;
    end
  end

  assign slot_skipped = pat_q[0];
  assign fetch_addr_o = pc_q;
  assign valid_o      = |pat_q;
  assign cancel_o     = stream_q & slot_skipped;
  assign stall_o      = busy;
  assign dropped_o    = drop_q;

  AST_LOAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && stream_mode_i) |=> (fetch_addr_o == PC_W'($past(operand_i[TGT_W-1:0])))); // R1
  AST_LOCAL_ON_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!stream_q && !busy) |-> !slot_skipped); // R2
  AST_STALL_LOCAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !stream_q); // R3
  AST_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_q && adv_i && !load_i && !branch_i) |=> (fetch_addr_o == $past(fetch_addr_o) + PC_W'(1))); // R4
  AST_BRANCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_i && !load_i) |=> (!valid_o && !stall_o && fetch_addr_o == $past(branch_addr_i))); // R6
  AST_LOAD_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && stream_mode_i) |=> (valid_o == ($past(operand_i[OP_W-1:TGT_W]) != '0))); // R7
  AST_NO_DROP_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    stream_q |-> (dropped_o == '0)); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !done && !load_i && !branch_i) |=> $stable(fetch_addr_o)); // R9
endmodule

// File: tb/skip_seq_tb.sv
`timescale 1ns/1ps
module skip_seq_tb_top;
  localparam int PC_W = 20;
  localparam int WIN  = 8;
  localparam int RC   = 2;
  localparam int PW   = 22;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            load_i = 1'b0;
  logic [31:0]     operand_i = '0;
  logic            branch_i = 1'b0;
  logic [PC_W-1:0] branch_addr_i = '0;
  logic            adv_i = 1'b0;
  logic            stream_mode_i = 1'b0;
  logic [PC_W-1:0] fetch_addr_o;
  logic            cancel_o, stall_o, valid_o;
  logic [3:0]      dropped_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  skip_seq #(.PC_W(PC_W), .WIN(WIN), .RELOAD_CYC(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .operand_i(operand_i),
    .branch_i(branch_i), .branch_addr_i(branch_addr_i), .adv_i(adv_i),
    .stream_mode_i(stream_mode_i), .fetch_addr_o(fetch_addr_o),
    .cancel_o(cancel_o), .stall_o(stall_o), .valid_o(valid_o), .dropped_o(dropped_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue_load(input logic [PW-1:0] pat, input logic [9:0] tgt, input bit strm);
    @(negedge clk);
    adv_i = 1'b0;
    load_i = 1'b1;
    operand_i = {pat, tgt};
    stream_mode_i = strm;
    @(posedge clk);
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_addr_o == 0, "R5", "reset addr", fetch_addr_o, 0);
    chk(!valid_o && !cancel_o && !stall_o, "R5", "reset flags",
        {valid_o, cancel_o, stall_o}, 0);
  endtask

  // Local mode: executed addresses, stall cycles and dropped-slot sum.
  task automatic t_local(input logic [PW-1:0] pat, input logic [9:0] tgt);
    int exp_a [0:PW+1];
    int n = 0, got = 0, cyc = 0, stalls = 0, dsum = 0, run = 0, est = 0, ones = 0;
    for (int k = 0; k < PW; k++) begin
      if (!pat[k]) begin
        exp_a[n] = tgt + k; n++;
        est += (run / WIN) * RC; run = 0;
      end else begin
        run++; ones++;
      end
    end
    est += (run / WIN) * RC;
    exp_a[n] = tgt + PW; n++;
    exp_a[n] = tgt + PW + 1; n++;
    issue_load(pat, tgt, 1'b0);
    adv_i = 1'b1;
    while (got < n && cyc < 200) begin
      cyc++;
      dsum += dropped_o;
      chk(!cancel_o, "R2", "local cancel", cancel_o, 0);
      if (stall_o) stalls++;
      else begin
        chk(fetch_addr_o == exp_a[got], "R2", "local exec addr", fetch_addr_o, exp_a[got]);
        got++;
      end
      if (got < n) @(negedge clk);
    end
    adv_i = 1'b0;
    chk(stalls == est, "R3", "stall cycles", stalls, est);
    chk(cyc == n + est, "R2", "total cycles", cyc, n + est);
    chk(dsum == ones, "R8", "dropped sum", dsum, ones);
    chk(!valid_o, "R5", "valid after consume", valid_o, 0);
  endtask

  // Streamed mode: every slot appears, skipped ones cancelled.
  task automatic t_stream(input logic [PW-1:0] pat, input logic [9:0] tgt);
    issue_load(pat, tgt, 1'b1);
    adv_i = 1'b1;
    for (int k = 0; k < PW + 2; k++) begin
      logic expc;
      expc = (k < PW) ? pat[k] : 1'b0;
      chk(fetch_addr_o == tgt + k, (k == 0) ? "R1" : "R4", "stream addr", fetch_addr_o, tgt + k);
      chk(cancel_o == expc, "R4", "stream cancel", cancel_o, expc);
      chk(!stall_o && dropped_o == 0, "R8", "stream stall/drop", {stall_o, dropped_o}, 0);
      chk(valid_o == ((pat >> k) != 0), "R5", "stream valid", valid_o, (pat >> k) != 0);
      @(negedge clk);
    end
    adv_i = 1'b0;
  endtask

  task automatic t_stall_hold();
    issue_load(22'h0003FF, 10'h100, 1'b0);
    adv_i = 1'b1;
    chk(stall_o && fetch_addr_o == 'h108, "R3", "first stall", fetch_addr_o, 'h108);
    chk(dropped_o == 8, "R8", "drop full window", dropped_o, 8);
    @(negedge clk);
    chk(stall_o && fetch_addr_o == 'h108, "R9", "held during stall", fetch_addr_o, 'h108);
    @(negedge clk);
    chk(!stall_o && fetch_addr_o == 'h10A, "R3", "after reload", fetch_addr_o, 'h10A);
    chk(dropped_o == 2, "R8", "drop tail", dropped_o, 2);
    adv_i = 1'b0;
  endtask

  task automatic t_branch();
    issue_load(22'h0003FF, 10'h040, 1'b0);
    chk(stall_o, "R3", "stall before branch", stall_o, 1);
    branch_i = 1'b1;
    branch_addr_i = 20'h5A5A5;
    @(posedge clk);
    @(negedge clk);
    branch_i = 1'b0;
    chk(!stall_o && !valid_o, "R6", "branch clears", {stall_o, valid_o}, 0);
    chk(fetch_addr_o == 20'h5A5A5, "R6", "branch addr", fetch_addr_o, 20'h5A5A5);
    adv_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    adv_i = 1'b0;
    chk(fetch_addr_o == 20'h5A5A7, "R6", "step after branch", fetch_addr_o, 20'h5A5A7);
  endtask

  task automatic t_replace();
    logic expc [0:3];
    expc[0] = 0; expc[1] = 0; expc[2] = 1; expc[3] = 0;
    issue_load(22'h3FFFFF, 10'h010, 1'b1);
    adv_i = 1'b1;
    @(negedge clk);
    chk(cancel_o, "R4", "old pattern cancel", cancel_o, 1);
    adv_i = 1'b0;
    issue_load(22'h000004, 10'h3F0, 1'b1);
    stream_mode_i = 1'b0;
    adv_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk(cancel_o == expc[k], "R7", "replaced cancel", cancel_o, expc[k]);
      chk(fetch_addr_o == 'h3F0 + k, "R10", "mode held addr", fetch_addr_o, 'h3F0 + k);
      chk(!stall_o, "R10", "no stall after mode flip", stall_o, 0);
      @(negedge clk);
    end
    adv_i = 1'b0;
    chk(!valid_o, "R7", "replaced pattern done", valid_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_local(22'h000000, 10'h020);
    t_local(22'h00007F, 10'h0A0);
    t_local(22'h0000FF, 10'h0B0);
    t_local(22'h007FFF, 10'h0C0);
    t_local(22'h3FFFFF, 10'h3FF);
    t_local(22'h2AAAAA, 10'h001);
    t_stall_hold();
    t_branch();
    t_stream(22'h3FFFFF, 10'h200);
    t_stream(22'h155555, 10'h2F0);
    t_replace();
    for (int i = 0; i < 8; i++) begin
      logic [PW-1:0] p;
      logic [9:0] t;
      p = PW'($urandom);
      if (i[0]) p = p | (PW'($urandom) & PW'($urandom) & 22'h3FFF00) | 22'h000FF0;
      t = 10'($urandom);
      t_local(p, t);
      t_stream(p, t);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule